// File: doc/BRIEF.md
# Interrupt Exception Sequence Timer

This block times the bus activity of a processor interrupt exception after the interrupt has been accepted. A start strobe begins a fixed list of fifteen phases: idle gaps, stack writes, the vector-number read, handler-address reads, prefetches and platform bus penalties. An optional wait lines the vector read up with a slow peripheral clock. While the sequence runs, the block shows the current phase code and a running cycle count. It captures the interrupt vector at the end of the vector-number read, and it pulses a done flag when the last prefetch has finished.

An exact mode uses the natural phase lengths. A coarse mode rounds every phase up to a multiple of four cycles. The peripheral clock is modelled as a free-running divide-by-`ECLK_DIV` counter. Up to the end of the vector read, a newer interrupt can overwrite the vector that will be captured. After that point the captured vector is frozen.

Top module: `irq_exc_seq`

## Requirements
- R1: After an accepted start, `phase_o` walks the codes 1..15 in increasing order, skipping any phase whose length is zero. It stays at each code for that phase's length. The exact lengths are: 1 idle 6, 2 entry penalty 2, 3 low-word write 4, 4 clock-sync wait, 5 vector read, 6 idle 4, 7 penalty 2, 8 status write 4, 9 high-word write 4, 10 handler-high read 4, 11 handler-low read 4, 12 prefetch 4, 13 idle 2, 14 penalty 2, 15 prefetch 4. `phase_o` is 0 exactly when `busy_o` is low.
- R2: Phase 5 (vector read) lasts 10 cycles when `autovec_i` was high at start and 12 cycles otherwise.
- R3: Phase 2 (entry penalty) lasts 2 cycles when `misalign_i` was high at start. Otherwise it lasts 0 cycles and is skipped. Phases 7 and 14 are always present.
- R4: Phase 4 (clock sync) exists only for auto-vectored starts. The divider counter is 0 during reset and advances by one, modulo `ECLK_DIV` (10), on every clock edge. Let e be the counter value in the first cycle of phase 4. The exact wait is ((ECLK_SYNC − e) mod ECLK_DIV) with bit 0 cleared, which gives 0..8 cycles in steps of 2. A zero wait skips the phase.
- R5: With `coarse_i` high at start, every phase length, including the wait, is rounded up to the next multiple of 4.
- R6: `elapsed_o` is 1 in the first busy cycle and rises by one each busy cycle. After the run it holds the total, which in exact mode is 44 + entry penalty + wait + vector-read length. An auto-vectored run with penalty and no wait therefore totals 56.
- R7: `vec_i` at start is the candidate vector. A `vec_valid_i` pulse in any busy cycle up to and including the last vector-read cycle replaces the candidate. In the cycle after the vector read, `vec_latched_o` rises and `vec_o` shows the candidate. Later `vec_valid_i` pulses have no effect. `vec_o` then holds until a new start.
- R8: `done_o` is high for exactly one cycle, the cycle after the last busy cycle, with `busy_o` low.
- R9: `start_i` is ignored while `busy_o` is high. The mode inputs are captured only at an accepted start.
- R10: During and right after reset, `busy_o`, `done_o` and `vec_latched_o` are 0, and `phase_o` and `elapsed_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a sequence (accepted when idle) |
| autovec_i | input | 1 | Interrupt is auto-vectored |
| misalign_i | input | 1 | Previous access misaligned; inserts entry penalty |
| coarse_i | input | 1 | 1 = coarse (4-cycle rounded) timing, 0 = exact |
| vec_i | input | VEC_W | Vector number |
| vec_valid_i | input | 1 | Newer vector present on `vec_i` |
| busy_o | output | 1 | Sequence running |
| phase_o | output | 4 | Current phase code, 0 when idle |
| elapsed_o | output | ELAP_W | Cycles elapsed in the current or last sequence |
| vec_o | output | VEC_W | Latched vector |
| vec_latched_o | output | 1 | Vector has been latched |
| done_o | output | 1 | One-cycle end pulse |

## Verification
The bench sweeps all eight combinations of auto-vector, misalignment and coarse mode. For each combination it uses ten start delays, so the divider counter sits at different positions when the sync wait begins, and it checks every cycle's phase code and count against lengths it computes itself. Each run places a vector replacement in one of three positions: on the last vector-read cycle, where it must win, one cycle later, where it must be ignored, or nowhere, where the start vector must remain. A second start, with inverted modes, arrives mid-run. It separates a design that re-captures its configuration from one that correctly ignores the strobe.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   localparam logic [3:0] PH_NONE  = 4'd0;
   localparam logic [3:0] PH_IDLE1 = 4'd1;
   localparam logic [3:0] PH_PEN1  = 4'd2;
   localparam logic [3:0] PH_WPCL  = 4'd3;
   localparam logic [3:0] PH_ESYNC = 4'd4;
   localparam logic [3:0] PH_VREAD = 4'd5;
   localparam logic [3:0] PH_IDLE2 = 4'd6;
   localparam logic [3:0] PH_PEN2  = 4'd7;
   localparam logic [3:0] PH_WSR   = 4'd8;
   localparam logic [3:0] PH_WPCH  = 4'd9;
   localparam logic [3:0] PH_RVH   = 4'd10;
   localparam logic [3:0] PH_RVL   = 4'd11;
   localparam logic [3:0] PH_PF1   = 4'd12;
   localparam logic [3:0] PH_IDLE3 = 4'd13;
   localparam logic [3:0] PH_PEN3  = 4'd14;
   localparam logic [3:0] PH_PF2   = 4'd15;

   localparam int unsigned LEN_IDLE_LONG  = 6;
   localparam int unsigned LEN_BUS        = 4;
   localparam int unsigned LEN_SHORT      = 2;
   localparam int unsigned LEN_VREAD_AUTO = 10;
   localparam int unsigned LEN_VREAD_PERI = 12;
endpackage

// File: rtl/irq_seq_eclk.sv
module irq_seq_eclk #(
   parameter int ECLK_DIV  = 10,
   parameter int ECLK_SYNC = 0,
   parameter int LEN_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [LEN_W-1:0] ewait_o
);
   localparam int CW = (ECLK_DIV > 1) ? $clog2(ECLK_DIV) : 1;

   generate
      if (ECLK_DIV > 1) begin : g_div
         logic [CW-1:0] cnt_q;
         logic [CW-1:0] cnt_nx;
         logic [CW:0]   raw;

         assign cnt_nx = (cnt_q == CW'(ECLK_DIV - 1)) ? '0 : cnt_q + CW'(1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_nx;
         end

         // wait measured from the value the counter holds in the next cycle
         always_comb begin
            if (CW'(ECLK_SYNC) >= cnt_nx)
               raw = (CW+1)'(ECLK_SYNC) - {1'b0, cnt_nx};
            else
               raw = (CW+1)'(ECLK_SYNC + ECLK_DIV) - {1'b0, cnt_nx};
            ewait_o = LEN_W'(raw) & ~LEN_W'(1);
         end
      end else begin : g_nodiv
         assign ewait_o = '0;
      end
   endgenerate
endmodule

// File: rtl/irq_seq_len.sv
module irq_seq_len #(
   parameter int LEN_W = 5
) (
   input  logic [3:0]       phase_i,
   input  logic             autovec_i,
   input  logic             misalign_i,
   input  logic             coarse_i,
   input  logic [LEN_W-1:0] ewait_i,
   output logic [LEN_W-1:0] len_o
);
   import irq_seq_pkg::*;
   logic [LEN_W-1:0] base;

   always_comb begin
      case (phase_i)
         PH_IDLE1:                     base = LEN_W'(LEN_IDLE_LONG);
         PH_PEN1:                      base = misalign_i ? LEN_W'(LEN_SHORT) : '0;
         PH_ESYNC:                     base = autovec_i ? ewait_i : '0;
         PH_VREAD:                     base = autovec_i ? LEN_W'(LEN_VREAD_AUTO)
                                                        : LEN_W'(LEN_VREAD_PERI);
         PH_PEN2, PH_IDLE3, PH_PEN3:   base = LEN_W'(LEN_SHORT);
         PH_NONE:                      base = '0;
         default:                      base = LEN_W'(LEN_BUS);
      endcase
      len_o = coarse_i ? ((base + LEN_W'(3)) & ~LEN_W'(3)) : base;
   end
endmodule

// File: rtl/irq_seq_vec.sv
module irq_seq_vec #(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  logic             busy_i,
   input  logic             latch_i,
   input  logic [VEC_W-1:0] vec_i,
   input  logic             vec_valid_i,
   output logic [VEC_W-1:0] vec_o,
   output logic             latched_o
);
   logic [VEC_W-1:0] cand_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q    <= '0;
         vec_o     <= '0;
         latched_o <= 1'b0;
      end else if (accept_i) begin
         cand_q    <= vec_i;
         latched_o <= 1'b0;
      end else if (busy_i && !latched_o) begin
         if (vec_valid_i) cand_q <= vec_i;
         if (latch_i) begin
            vec_o     <= vec_valid_i ? vec_i : cand_q;
            latched_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_exc_seq.sv
module irq_exc_seq #(
   parameter int VEC_W     = 8,
   parameter int ELAP_W    = 8,
   parameter int ECLK_DIV  = 10,
   parameter int ECLK_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              autovec_i,
   input  logic              misalign_i,
   input  logic              coarse_i,
   input  logic [VEC_W-1:0]  vec_i,
   input  logic              vec_valid_i,
   output logic              busy_o,
   output logic [3:0]        phase_o,
   output logic [ELAP_W-1:0] elapsed_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic              vec_latched_o,
   output logic              done_o
);
   import irq_seq_pkg::*;
   localparam int LEN_W   = $clog2(ECLK_DIV + 16);
   localparam int MAX_TOT = 64 + ECLK_DIV + 4;

   generate
      if (ECLK_DIV < 1 || ECLK_SYNC < 0 || ECLK_SYNC >= ECLK_DIV) begin : g_bad_eclk
         $error("irq_exc_seq: ECLK_SYNC must lie in 0..ECLK_DIV-1");
      end
      if ((1 << ELAP_W) <= MAX_TOT) begin : g_bad_elap
         $error("irq_exc_seq: ELAP_W too small for the longest sequence");
      end
      if (VEC_W < 1) begin : g_bad_vec
         $error("irq_exc_seq: VEC_W must be positive");
      end
   endgenerate

   logic              busy_q, done_q, auto_q, mis_q, crs_q;
   logic [3:0]        ph_q;
   logic [LEN_W-1:0]  rem_q;
   logic [ELAP_W-1:0] elap_q;
   logic [LEN_W-1:0]  ewait, len_first, len_a, len_b;
   logic [3:0]        ph_a, ph_b;
   logic              accept, last;

   assign accept = start_i & ~busy_q;
   assign last   = busy_q & (rem_q == '0);
   assign ph_a   = ph_q + 4'd1;
   assign ph_b   = ph_q + 4'd2;

   irq_seq_eclk #(.ECLK_DIV(ECLK_DIV), .ECLK_SYNC(ECLK_SYNC), .LEN_W(LEN_W)) u_eclk (
      .clk(clk), .rst_n(rst_n), .ewait_o(ewait));

   irq_seq_len #(.LEN_W(LEN_W)) u_len_first (
      .phase_i(PH_IDLE1), .autovec_i(autovec_i), .misalign_i(misalign_i),
      .coarse_i(coarse_i), .ewait_i(ewait), .len_o(len_first));

   irq_seq_len #(.LEN_W(LEN_W)) u_len_a (
      .phase_i(ph_a), .autovec_i(auto_q), .misalign_i(mis_q),
      .coarse_i(crs_q), .ewait_i(ewait), .len_o(len_a));

   irq_seq_len #(.LEN_W(LEN_W)) u_len_b (
      .phase_i(ph_b), .autovec_i(auto_q), .misalign_i(mis_q),
      .coarse_i(crs_q), .ewait_i(ewait), .len_o(len_b));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         ph_q   <= PH_NONE;
         rem_q  <= '0;
         elap_q <= '0;
         auto_q <= 1'b0;
         mis_q  <= 1'b0;
         crs_q  <= 1'b0;
      end else if (accept) begin
         busy_q <= 1'b1;
         done_q <= 1'b0;
         ph_q   <= PH_IDLE1;
         rem_q  <= len_first - LEN_W'(1);
         elap_q <= ELAP_W'(1);
         auto_q <= autovec_i;
         mis_q  <= misalign_i;
         crs_q  <= coarse_i;
      end else if (busy_q) begin
         if (last && ph_q == PH_PF2) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            ph_q   <= PH_NONE;
         end else begin
            elap_q <= elap_q + ELAP_W'(1);
            if (!last) begin
               rem_q <= rem_q - LEN_W'(1);
            end else if (len_a != '0) begin
               ph_q  <= ph_a;
               rem_q <= len_a - LEN_W'(1);
            end else begin
               ph_q  <= ph_b;
               rem_q <= len_b - LEN_W'(1);
            end
         end
      end else begin
         done_q <= 1'b0;
      end
   end

   irq_seq_vec #(.VEC_W(VEC_W)) u_vec (
      .clk(clk), .rst_n(rst_n), .accept_i(accept), .busy_i(busy_q),
      .latch_i(last && ph_q == PH_VREAD), .vec_i(vec_i), .vec_valid_i(vec_valid_i),
      .vec_o(vec_o), .latched_o(vec_latched_o));

   assign busy_o    = busy_q;
   assign phase_o   = ph_q;
   assign elapsed_o = elap_q;
   assign done_o    = done_q;
endmodule

// File: rtl/irq_exc_seq_chk.sv
module irq_exc_seq_chk #(
   parameter int VEC_W  = 8,
   parameter int ELAP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic [3:0]        phase_o,
   input logic [ELAP_W-1:0] elapsed_o,
   input logic [VEC_W-1:0]  vec_o,
   input logic              vec_latched_o,
   input logic              done_o
);
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R1
   phase_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o == (phase_o != 4'd0));
   // R1
   phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> (phase_o >= $past(phase_o)));
   // R6
   elapsed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> (elapsed_o == $past(elapsed_o) + ELAP_W'(1)));
   // R7
   vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_latched_o && $past(vec_latched_o)) |-> $stable(vec_o));
endmodule

bind irq_exc_seq irq_exc_seq_chk #(.VEC_W(VEC_W), .ELAP_W(ELAP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .phase_o(phase_o),
   .elapsed_o(elapsed_o), .vec_o(vec_o), .vec_latched_o(vec_latched_o),
   .done_o(done_o));

// File: tb/sim_irq_exc_seq.sv
`timescale 1ns/1ps
module sim_irq_exc_seq;
   localparam int VEC_W = 8;
   localparam int ELAP_W = 8;
   localparam int DIV = 10;
   localparam int SYNC = 0;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 0, autovec_i = 0, misalign_i = 0, coarse_i = 0, vec_valid_i = 0;
   logic [VEC_W-1:0] vec_i = '0;
   logic busy_o, vec_latched_o, done_o;
   logic [3:0] phase_o;
   logic [ELAP_W-1:0] elapsed_o;
   logic [VEC_W-1:0] vec_o;
   int checks = 0, errors = 0, edges = 0;

   always #10 clk = ~clk;
   always @(posedge clk) if (!rst_n) edges <= 0; else edges <= edges + 1;

   irq_exc_seq #(.VEC_W(VEC_W), .ELAP_W(ELAP_W), .ECLK_DIV(DIV), .ECLK_SYNC(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .autovec_i(autovec_i),
      .misalign_i(misalign_i), .coarse_i(coarse_i), .vec_i(vec_i),
      .vec_valid_i(vec_valid_i), .busy_o(busy_o), .phase_o(phase_o),
      .elapsed_o(elapsed_o), .vec_o(vec_o), .vec_latched_o(vec_latched_o),
      .done_o(done_o));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int rnd4(input int v, input bit c);
      return c ? ((v + 3) / 4) * 4 : v;
   endfunction

   // exact lengths from R1..R4, rounded per R5
   function automatic int plen(input int p, input bit a, input bit m, input bit c, input int w);
      int b;
      case (p)
         1: b = 6;
         2: b = m ? 2 : 0;
         4: b = a ? w : 0;
         5: b = a ? 10 : 12;
         7, 13, 14: b = 2;
         default: b = 4;
      endcase
      return rnd4(b, c);
   endfunction

   task automatic run(input bit a, input bit m, input bit c, input int dly, input int mode,
                      input int idx);
      int lens[16];
      int es, e, w, off, total, vend, ph, inph, bad_ph, bad_el, bad_lt, bad_bz;
      logic [VEC_W-1:0] v0, vexp;
      v0 = VEC_W'(idx);
      repeat (dly) @(negedge clk);
      start_i = 1; autovec_i = a; misalign_i = m; coarse_i = c; vec_i = v0; vec_valid_i = 0;
      @(negedge clk);
      start_i = 0;
      es = edges % DIV;
      for (int p = 1; p < 16; p++) lens[p] = plen(p, a, m, c, 0);
      off = lens[1] + lens[2] + lens[3];
      e = (es + off) % DIV;
      w = ((SYNC - e + DIV) % DIV) & ~1;
      lens[4] = plen(4, a, m, c, w);
      total = 0;
      for (int p = 1; p < 16; p++) total += lens[p];
      vend = off + lens[4] + lens[5];
      vexp = (mode == 0) ? VEC_W'(idx + 100) : v0;
      ph = 1; inph = 0; bad_ph = 0; bad_el = 0; bad_lt = 0; bad_bz = 0;
      for (int i = 1; i <= total; i++) begin
         while (lens[ph] == 0) ph++;
         if (phase_o != 4'(ph)) bad_ph++;
         if (elapsed_o != ELAP_W'(i)) bad_el++;
         if (vec_latched_o != (i > vend)) bad_lt++;
         if (!busy_o || done_o) bad_bz++;
         inph++;
         if (inph == lens[ph]) begin ph++; inph = 0; end
         // R9: a second start with inverted modes is ignored
         start_i = (i == 3);
         autovec_i = (i == 3) ? ~a : a; misalign_i = (i == 3) ? ~m : m;
         coarse_i = (i == 3) ? ~c : c;
         vec_valid_i = (mode == 0 && i == vend) || (mode == 1 && i == vend + 1);
         vec_i = vec_valid_i ? VEC_W'(idx + 100) : v0;
         @(negedge clk);
      end
      start_i = 0; vec_valid_i = 0;
      chk(bad_ph == 0, "R1/R2/R3/R4/R5 phase sequence", bad_ph, 0);
      chk(bad_el == 0, "R6 elapsed count", bad_el, 0);
      chk(bad_lt == 0, "R7 latch timing", bad_lt, 0);
      chk(bad_bz == 0, "R9 busy through run", bad_bz, 0);
      chk(!busy_o && done_o && phase_o == 0, "R8 done pulse", {busy_o, done_o}, 1);
      chk(elapsed_o == ELAP_W'(total), "R6 total", elapsed_o, total);
      chk(vec_o == vexp && vec_latched_o, "R7 vector", vec_o, vexp);
      @(negedge clk);
      chk(!done_o, "R8 done single cycle", done_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy_o && !done_o && !vec_latched_o && phase_o == 0 && elapsed_o == 0,
          "R10 reset state", {busy_o, done_o, vec_latched_o}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(!busy_o && phase_o == 0 && elapsed_o == 0, "R10 after reset", phase_o, 0);
      for (int cfg = 0; cfg < 8; cfg++)
         for (int d = 0; d < 10; d++)
            run(cfg[0], cfg[1], cfg[2], d, (cfg + d) % 3, cfg * 10 + d);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule